// File: doc/BRIEF.md
# Receiver Detection Scheduler with Polling Start Gate

This block decides when a downstream SuperSpeed port asks its PHY to probe for a far-end receiver, and when the link may begin sending Polling LFPS once a receiver has been seen. It watches the current link state, the PHY's electrical-idle indication, an exit-LFPS strobe and the PHY's detection result. From these it raises a detection request, reports each completed probe with a one-cycle strobe, keeps a far-end-present flag, and opens a polling-start enable after an optional settling delay.

The block runs automatic probes with a retry timeout between attempts. Configuration inputs change that schedule. A skip option passes over an attempt while the line is not idle. An abort option drops an attempt in U2 when the partner sends an exit LFPS. A manual-only mode stops automatic probing in Rx.Detect and U3, so that a probe starts only on a rising edge of a start bit. A delay-disable bit removes the 400 µs settling wait before polling. The analog detection itself and the link state decisions are made outside this block.

Top module: `rxdet_poll_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs return to 0. On release, the sequencer is idle and the polling delay counter is empty.
- R2: The link state encoding is 2'b00 other, 2'b01 Rx.Detect, 2'b10 U2, 2'b11 U3. An automatic attempt starts from idle in U2, and in Rx.Detect or U3 when `cfg_manual_only` is 0. It never starts in the other state. Once raised, `det_req` stays high until `det_done`, an abort, or a move to the other state. Only one request is outstanding at a time.
- R3: `det_done` during a request makes `det_valid` high for exactly one cycle after that clock edge, and `far_present` takes `det_present` on the same edge. `det_done` without a request has no effect on any output.
- R4: After an automatic attempt completes or is skipped, `det_req` stays low for TIMEOUT_CYC+1 cycles and then rises again if the state still allows an attempt.
- R5: With `cfg_skip`=1 and `rx_elec_idle`=0, an automatic attempt is skipped: no request and no result strobe. The retry timeout is loaded instead, and the attempt is repeated after it.
- R6: With `cfg_abort_u2`=1, link state U2 and `exit_lfps` high during a request, the request ends with no `det_valid` and `far_present` unchanged. In any other state, or with the bit clear, `exit_lfps` has no effect.
- R7: With `cfg_manual_only`=1, no automatic attempt starts in Rx.Detect or U3.
- R8: With `cfg_manual_only`=1 in Rx.Detect or U3, a 0-to-1 edge on `cfg_manual_start` while idle raises `det_req` on the next clock edge. A level held high starts nothing more. A completed manual probe returns to idle with no retry timeout.
- R9: With `cfg_no_poll_delay`=0, `poll_start_en` requires Rx.Detect, `far_present`=1, and POLL_DELAY_CYC cycles elapsed since the completing edge. The counter is loaded on every completed probe.
- R10: With `cfg_no_poll_delay`=1, `poll_start_en` is high whenever the state is Rx.Detect and `far_present` is 1.
- R11: Entering the other state cancels a request or retry wait, and the sequencer goes back to idle. Leaving Rx.Detect clears the polling delay counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_state | input | 2 | Current link state (encoding in R2) |
| rx_elec_idle | input | 1 | PHY receiver electrical idle |
| exit_lfps | input | 1 | Partner exit LFPS detected |
| det_done | input | 1 | PHY has finished a detection |
| det_present | input | 1 | PHY detection result, valid with `det_done` |
| cfg_skip | input | 1 | Skip attempts while line not idle |
| cfg_abort_u2 | input | 1 | Abort on exit LFPS in U2 |
| cfg_manual_start | input | 1 | Manual start, acts on rising edge |
| cfg_manual_only | input | 1 | Disable automatic probes in Rx.Detect and U3 |
| cfg_no_poll_delay | input | 1 | Remove settling delay before polling |
| det_req | output | 1 | Detection request to the PHY |
| det_valid | output | 1 | One-cycle completed-probe strobe |
| far_present | output | 1 | Last completed probe found a receiver |
| poll_start_en | output | 1 | Polling LFPS may start |

## Verification
A request appears one clock edge after its cause: the start condition from idle, or the manual rising edge. The result strobe and the presence flag follow the `det_done` edge by one edge. The retry gap is TIMEOUT_CYC+1 sampled cycles of low request, and the polling enable rises POLL_DELAY_CYC cycles after the completing edge. Inputs are driven and outputs sampled on the falling clock edge, so each check reads the state left by a known number of rising edges. The retry gap and the polling delay are measured by counting low samples and comparing them to these exact figures.

// File: rtl/rxdet_pkg.sv
// Shared encodings for the receiver detection scheduler.
package rxdet_pkg;
    // Link state as seen by the scheduler.
    typedef enum logic [1:0] {
        LS_OTHER = 2'b00,
        LS_RXDET = 2'b01,
        LS_U2    = 2'b10,
        LS_U3    = 2'b11
    } link_st_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_REQ  = 2'b01,
        SQ_WAIT = 2'b10
    } seq_st_e;
endpackage

// File: rtl/rxdet_edge.sv
// Rising-edge detector for a level input.
// Assumes the level is already in the clock domain. The output is
// combinational from the input and one stored sample.
module rxdet_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Keep the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/rxdet_seq.sv
// Detection sequencer: decides when to request a probe, and handles
// skip, abort, manual start and the retry timeout.
// Assumes det_done is a strobe that is meaningful only while det_req is high.
module rxdet_seq
    import rxdet_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] link_state,
    input  logic       rx_elec_idle,
    input  logic       exit_lfps,
    input  logic       det_done,
    input  logic       det_present,
    input  logic       cfg_skip,
    input  logic       cfg_abort_u2,
    input  logic       cfg_manual_only,
    input  logic       man_rise,
    output logic       det_req,
    output logic       det_valid,
    output logic       far_present,
    output logic       det_cmpl
);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(TIMEOUT_CYC - 1);

    seq_st_e          state_q;
    logic [TMR_W-1:0] tmr_q;
    logic             req_manual_q;
    logic             valid_q;
    logic             far_q;

    logic in_rxdet, in_u2, in_u3, in_other, man_state;
    logic auto_ok, man_go, skip_now, abort_now;
    seq_st_e after_st;

    // Decode the link state and the start, skip and abort conditions.
    always_comb begin
        in_rxdet  = (link_state == LS_RXDET);
        in_u2     = (link_state == LS_U2);
        in_u3     = (link_state == LS_U3);
        in_other  = (link_state == LS_OTHER);
        man_state = in_rxdet | in_u3;
        auto_ok   = (man_state & ~cfg_manual_only) | in_u2;
        man_go    = man_state & cfg_manual_only & man_rise;
        skip_now  = cfg_skip & ~rx_elec_idle;
        abort_now = cfg_abort_u2 & in_u2 & exit_lfps;
        after_st  = req_manual_q ? SQ_IDLE : SQ_WAIT;
        det_cmpl  = (state_q == SQ_REQ) & det_done & ~abort_now & ~in_other;
    end

    // Sequencer state, retry timer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SQ_IDLE;
            tmr_q        <= '0;
            req_manual_q <= 1'b0;
            valid_q      <= 1'b0;
            far_q        <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (man_go) begin
                        state_q      <= SQ_REQ;
                        req_manual_q <= 1'b1;
                    end else if (auto_ok) begin
                        req_manual_q <= 1'b0;
                        if (skip_now) begin
                            state_q <= SQ_WAIT;
                            tmr_q   <= TMR_LOAD;
                        end else begin
                            state_q <= SQ_REQ;
                        end
                    end
                end
                SQ_REQ: begin
                    if (in_other) begin
                        state_q <= SQ_IDLE;
                    end else if (abort_now) begin
                        state_q <= after_st;
                        tmr_q   <= TMR_LOAD;
                    end else if (det_done) begin
                        valid_q <= 1'b1;
                        far_q   <= det_present;
                        state_q <= after_st;
                        tmr_q   <= TMR_LOAD;
                    end
                end
                SQ_WAIT: begin
                    if (in_other || tmr_q == '0) state_q <= SQ_IDLE;
                    else                         tmr_q   <= tmr_q - 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign det_req     = (state_q == SQ_REQ);
    assign det_valid   = valid_q;
    assign far_present = far_q;
endmodule

// File: rtl/rxdet_poll_gate.sv
// Polling start gate: holds polling off for a settling delay after each
// completed probe, unless the delay is disabled.
// Assumes det_cmpl is high for one cycle on the completing edge.
module rxdet_poll_gate #(
    parameter int POLL_DELAY_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_rxdet,
    input  logic det_cmpl,
    input  logic far_present,
    input  logic cfg_no_poll_delay,
    output logic poll_start_en
);
    localparam int CNT_W = $clog2(POLL_DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(POLL_DELAY_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Load on completion, count down, clear outside Rx.Detect.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!in_rxdet)    cnt_q <= '0;
        else if (det_cmpl)     cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign poll_start_en = in_rxdet & far_present & (cfg_no_poll_delay | (cnt_q == '0));
endmodule

// File: rtl/rxdet_poll_ctrl.sv
// Top: receiver detection scheduler with polling start gate for a
// downstream port. Runs on the 8 ns link clock, synchronous active-low reset.
// Assumes all inputs are synchronous to clk.
module rxdet_poll_ctrl
    import rxdet_pkg::*;
#(
    parameter int TIMEOUT_CYC    = 1500000,
    parameter int POLL_DELAY_CYC = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] link_state,
    input  logic       rx_elec_idle,
    input  logic       exit_lfps,
    input  logic       det_done,
    input  logic       det_present,
    input  logic       cfg_skip,
    input  logic       cfg_abort_u2,
    input  logic       cfg_manual_start,
    input  logic       cfg_manual_only,
    input  logic       cfg_no_poll_delay,
    output logic       det_req,
    output logic       det_valid,
    output logic       far_present,
    output logic       poll_start_en
);
    logic man_rise;
    logic det_cmpl;
    logic in_rxdet;

    assign in_rxdet = (link_state == LS_RXDET);

    rxdet_edge #(.W(1)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (cfg_manual_start),
        .rise  (man_rise)
    );

    rxdet_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .link_state      (link_state),
        .rx_elec_idle    (rx_elec_idle),
        .exit_lfps       (exit_lfps),
        .det_done        (det_done),
        .det_present     (det_present),
        .cfg_skip        (cfg_skip),
        .cfg_abort_u2    (cfg_abort_u2),
        .cfg_manual_only (cfg_manual_only),
        .man_rise        (man_rise),
        .det_req         (det_req),
        .det_valid       (det_valid),
        .far_present     (far_present),
        .det_cmpl        (det_cmpl)
    );

    rxdet_poll_gate #(.POLL_DELAY_CYC(POLL_DELAY_CYC)) u_poll (
        .clk               (clk),
        .rst_n             (rst_n),
        .in_rxdet          (in_rxdet),
        .det_cmpl          (det_cmpl),
        .far_present       (far_present),
        .cfg_no_poll_delay (cfg_no_poll_delay),
        .poll_start_en     (poll_start_en)
    );
endmodule

// File: rtl/rxdet_poll_ctrl_chk.sv
// Property checker for rxdet_poll_ctrl, attached by bind below.
module rxdet_poll_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] link_state,
    input logic       exit_lfps,
    input logic       det_done,
    input logic       cfg_abort_u2,
    input logic       cfg_no_poll_delay,
    input logic       det_req,
    input logic       det_valid,
    input logic       far_present,
    input logic       poll_start_en
);
    // R2: an open request holds until done, abort or the other state.
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (det_req && !det_done && link_state != 2'b00 &&
         !(cfg_abort_u2 && link_state == 2'b10 && exit_lfps)) |=> det_req);

    // R3: the result strobe lasts one cycle.
    assert_valid_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |=> !det_valid);

    // R3: a result follows a request.
    assert_valid_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> $past(det_req));

    // R3: the presence flag moves only with a result.
    assert_far_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !det_valid |-> $stable(far_present));

    // R6: an abort produces no result.
    assert_abort_no_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (det_req && cfg_abort_u2 && link_state == 2'b10 && exit_lfps) |=> (!det_valid && !det_req));

    // R9: polling needs Rx.Detect and a present receiver.
    assert_poll_needs_far_R9: assert property (@(posedge clk) disable iff (!rst_n)
        poll_start_en |-> (link_state == 2'b01 && far_present));

    // R10: with the delay disabled, polling opens at once.
    assert_poll_nodelay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_no_poll_delay && far_present && link_state == 2'b01) |-> poll_start_en);

    // R11: the other state leaves no request open.
    assert_other_cancels_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b00) |=> !det_req);
endmodule

bind rxdet_poll_ctrl rxdet_poll_ctrl_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .link_state        (link_state),
    .exit_lfps         (exit_lfps),
    .det_done          (det_done),
    .cfg_abort_u2      (cfg_abort_u2),
    .cfg_no_poll_delay (cfg_no_poll_delay),
    .det_req           (det_req),
    .det_valid         (det_valid),
    .far_present       (far_present),
    .poll_start_en     (poll_start_en)
);

// File: tb/rxdet_poll_ctrl_bench.sv
// Self-checking bench for rxdet_poll_ctrl; drives and samples on falling edges.
module rxdet_poll_ctrl_bench;
    localparam int CLK_PERIOD_NS = 8;
    localparam int T_CYC = 40;
    localparam int P_CYC = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] link_state = 2'b00;
    logic       rx_elec_idle = 1'b1;
    logic       exit_lfps = 1'b0;
    logic       det_done = 1'b0;
    logic       det_present = 1'b0;
    logic       cfg_skip = 1'b0;
    logic       cfg_abort_u2 = 1'b0;
    logic       cfg_manual_start = 1'b0;
    logic       cfg_manual_only = 1'b0;
    logic       cfg_no_poll_delay = 1'b0;
    logic       det_req, det_valid, far_present, poll_start_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    rxdet_poll_ctrl #(.TIMEOUT_CYC(T_CYC), .POLL_DELAY_CYC(P_CYC)) u_rxdet_poll_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .link_state        (link_state),
        .rx_elec_idle      (rx_elec_idle),
        .exit_lfps         (exit_lfps),
        .det_done          (det_done),
        .det_present       (det_present),
        .cfg_skip          (cfg_skip),
        .cfg_abort_u2      (cfg_abort_u2),
        .cfg_manual_start  (cfg_manual_start),
        .cfg_manual_only   (cfg_manual_only),
        .cfg_no_poll_delay (cfg_no_poll_delay),
        .det_req           (det_req),
        .det_valid         (det_valid),
        .far_present       (far_present),
        .poll_start_en     (poll_start_en)
    );

    // Vectors: {link_state[1:0], manual_only, skip, elec_idle, expected det_req}
    localparam int NVEC = 9;
    localparam logic [5:0] VEC [NVEC] = '{
        {2'b01, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'b01, 1'b0, 1'b1, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b1, 1'b1},
        {2'b00, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        exit_lfps = 1'b0;
        det_done = 1'b0;
        det_present = 1'b0;
        cfg_manual_start = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic defaults(input logic [1:0] ls);
        link_state = ls;
        rx_elec_idle = 1'b1;
        cfg_skip = 1'b0;
        cfg_abort_u2 = 1'b0;
        cfg_manual_only = 1'b0;
        cfg_no_poll_delay = 1'b0;
    endtask

    task automatic pulse_done(input logic pres);
        det_done = 1'b1;
        det_present = pres;
        tick();
        det_done = 1'b0;
        det_present = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lows;
        int highs;
        int flag;
        // R1: outputs during reset
        defaults(2'b01);
        rst_n = 1'b0;
        repeat (3) tick();
        check("R1 req", int'(det_req), 0);
        check("R1 valid", int'(det_valid), 0);
        check("R1 far", int'(far_present), 0);
        check("R1 poll", int'(poll_start_en), 0);

        // Vector table: start conditions (R2, R5, R7)
        for (int i = 0; i < NVEC; i++) begin
            defaults(VEC[i][5:4]);
            cfg_manual_only = VEC[i][3];
            cfg_skip = VEC[i][2];
            rx_elec_idle = VEC[i][1];
            do_reset();
            tick();
            tick();
            check($sformatf("R2/R5/R7 vector %0d req", i), int'(det_req), int'(VEC[i][0]));
        end

        // R3 and R9: present result, then polling delay
        defaults(2'b01);
        do_reset();
        tick();
        check("R2 req raised", int'(det_req), 1);
        pulse_done(1'b1);
        check("R3 valid", int'(det_valid), 1);
        check("R3 far", int'(far_present), 1);
        check("R9 poll early", int'(poll_start_en), 0);
        tick();
        check("R3 valid one cycle", int'(det_valid), 0);
        repeat (P_CYC - 2) tick();
        check("R9 poll before delay", int'(poll_start_en), 0);
        tick();
        check("R9 poll after delay", int'(poll_start_en), 1);

        // R4: failed result, retry gap
        defaults(2'b01);
        do_reset();
        tick();
        pulse_done(1'b0);
        check("R3 valid fail", int'(det_valid), 1);
        check("R3 far fail", int'(far_present), 0);
        lows = 0;
        while (det_req == 1'b0 && lows < 500) begin
            lows++;
            tick();
        end
        check("R4 retry gap", lows, T_CYC + 1);

        // R10: no polling delay
        defaults(2'b01);
        cfg_no_poll_delay = 1'b1;
        do_reset();
        tick();
        pulse_done(1'b1);
        check("R10 poll immediate", int'(poll_start_en), 1);

        // R11: leaving Rx.Detect clears the delay counter
        defaults(2'b01);
        do_reset();
        tick();
        pulse_done(1'b1);
        check("R11 poll held", int'(poll_start_en), 0);
        link_state = 2'b11;
        tick();
        link_state = 2'b01;
        tick();
        check("R11 counter cleared", int'(poll_start_en), 1);

        // R11: other state cancels; R3: stray done ignored
        defaults(2'b01);
        do_reset();
        tick();
        link_state = 2'b00;
        tick();
        check("R11 cancel", int'(det_req), 0);
        pulse_done(1'b1);
        check("R3 stray done valid", int'(det_valid), 0);
        check("R3 stray done far", int'(far_present), 0);
        repeat (4) tick();
        check("R11 stays idle", int'(det_req), 0);

        // R5: skip while line busy, then resume
        defaults(2'b01);
        cfg_skip = 1'b1;
        rx_elec_idle = 1'b0;
        do_reset();
        highs = 0;
        flag = 0;
        for (int k = 0; k < 3 * T_CYC; k++) begin
            tick();
            if (det_req) highs++;
            if (det_valid) flag = 1;
        end
        check("R5 no request while skipping", highs, 0);
        check("R5 no result while skipping", flag, 0);
        rx_elec_idle = 1'b1;
        lows = 0;
        while (det_req == 1'b0 && lows < 500) begin
            lows++;
            tick();
        end
        check("R5 resume within timeout", int'(lows <= T_CYC + 2), 1);

        // R6: abort in U2
        defaults(2'b10);
        cfg_abort_u2 = 1'b1;
        do_reset();
        tick();
        pulse_done(1'b1);
        lows = 0;
        while (det_req == 1'b0 && lows < 500) begin
            lows++;
            tick();
        end
        exit_lfps = 1'b1;
        tick();
        exit_lfps = 1'b0;
        check("R6 abort drops req", int'(det_req), 0);
        check("R6 abort no valid", int'(det_valid), 0);
        check("R6 abort keeps far", int'(far_present), 1);

        // R6: exit LFPS ignored with bit clear
        defaults(2'b10);
        do_reset();
        tick();
        exit_lfps = 1'b1;
        tick();
        exit_lfps = 1'b0;
        check("R6 ignored bit clear", int'(det_req), 1);

        // R6: exit LFPS ignored outside U2
        defaults(2'b01);
        cfg_abort_u2 = 1'b1;
        do_reset();
        tick();
        exit_lfps = 1'b1;
        tick();
        exit_lfps = 1'b0;
        check("R6 ignored outside U2", int'(det_req), 1);

        // R7, R8: manual mode
        defaults(2'b01);
        cfg_manual_only = 1'b1;
        do_reset();
        repeat (3) tick();
        check("R7 no auto", int'(det_req), 0);
        cfg_manual_start = 1'b1;
        tick();
        check("R8 edge starts", int'(det_req), 1);
        pulse_done(1'b1);
        check("R8 manual valid", int'(det_valid), 1);
        highs = 0;
        for (int k = 0; k < 6; k++) begin
            tick();
            if (det_req) highs++;
        end
        check("R8 level ignored", highs, 0);
        cfg_manual_start = 1'b0;
        tick();
        cfg_manual_start = 1'b1;
        tick();
        check("R8 second edge no timeout", int'(det_req), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule